// File: doc/BRIEF.md
# Time-Multiplexed Multi-Channel Sine Synthesizer

This block generates several independent sine waves, one per speed channel, from a single quarter-wave sine table. Every channel keeps its own phase accumulator. A phase increment input sets the channel's frequency, and an amplitude input scales its output. An external slew-limited tracker is expected to drive each increment, so the block samples the increments as they arrive and does not ramp them itself.

A round-robin slot counter visits one channel per clock. In that slot the channel's accumulator advances by its increment. The top phase bits then address the shared table, with a quadrant fold that rebuilds the full period. The signed sample is scaled by the channel's amplitude and written into that channel's output register, together with a one-cycle valid pulse. With the default five channels and a 40 MHz system clock, each channel is updated at 8 MHz.

Top module: `mc_dds`

## Requirements
- R1: A slot counter serves channels 0, 1, ..., N_CH-1 and then wraps to 0, one per clock. The first clock edge after reset is released serves channel 0. Valid pulses therefore appear in that same channel order.
- R2: Each channel holds a 32-bit phase accumulator. In its slot the accumulator adds the channel's increment, modulo 2^32. The phase used for the sample is the accumulator value after that addition.
- R3: A channel's accumulator changes only in its own slot. Another channel's increment has no effect on it.
- R4: The table holds 256 entries. Entry k is round(32767 * sin(3.141592653589793 * (k + 0.5) / 512)), rounded half up.
- R5: Phase bits [31:30] select the quadrant and bits [29:22] give the index. Quadrants 1 and 3 read entry 255-index, and quadrants 0 and 2 read entry index. Quadrants 2 and 3 negate the entry.
- R6: The amplitude is an unsigned 16-bit fraction. The output is the signed product of sample and amplitude divided by 2^16, rounded toward zero and kept at 16 bits. An amplitude of 0 gives 0.
- R7: A channel is served at clock edge e using the increment present at edge e. Its result is written to its output register at edge e+3, using the amplitude present at edge e+2.
- R8: valid_o has at most one bit set. The set bit marks the single channel whose output register was written at the last edge. A channel's output holds its value whenever its valid bit is low.
- R9: While rst_ni is low, all outputs, valid bits and accumulators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| incr_i | input | N_CH*32 | Per-channel phase increments; channel c at bits [c*32 +: 32] |
| amp_i | input | N_CH*16 | Per-channel unsigned amplitude fractions; channel c at bits [c*16 +: 16] |
| wave_o | output | N_CH*16 | Per-channel signed sine samples; channel c at bits [c*16 +: 16] |
| valid_o | output | N_CH | Per-channel one-cycle update pulse |

## Verification
The slot served at edge e samples its increment at that edge, has its table read registered at e+1, samples its amplitude at e+2, and appears at wave_o and valid_o at e+3. The bench counts edges from reset release and samples the outputs on the falling clock edge. It keeps its own four-entry pipeline of slot records, so each record is resolved against the outputs exactly three edges after its slot. Inputs change only after the checks of a falling edge. Each value a slot consumes is therefore the value the bench held at the matching rising edge.

// File: rtl/mc_dds_pkg.sv
package mc_dds_pkg;

  // Quarter-wave entry, sampled at half-step offsets so the fold is symmetric
  function automatic int quarter_sine(int k, int depth, int peak);
    real ang;
    ang = 3.141592653589793 * (real'(k) + 0.5) / (2.0 * real'(depth));
    return $rtoi($sin(ang) * real'(peak) + 0.5);
  endfunction

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mc_dds_slot.sv
module mc_dds_slot #(
  parameter int N_CH = 5,
  parameter int CW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] slot_o
);

  localparam logic [CW-1:0] LAST = CW'(N_CH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_o <= '0;
    else if (slot_o == LAST) slot_o <= '0;
    else                     slot_o <= slot_o + 1'b1;
  end

  assert_slot_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o == LAST |=> slot_o == '0);

  assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o != LAST |=> slot_o == $past(slot_o) + 1'b1);

  assert_slot_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o <= LAST);

endmodule

// File: rtl/mc_dds_phase.sv
module mc_dds_phase #(
  parameter int N_CH = 5,
  parameter int PW   = 32,
  parameter int CW   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    slot_i,
  input  logic [N_CH*PW-1:0] incr_i,
  output logic [PW-1:0]    phase_o,
  output logic [CW-1:0]    ch_o,
  output logic             vld_o
);

  logic [PW-1:0] acc_q [N_CH];
  logic [PW-1:0] acc_sel, inc_sel, sum;

  always_comb begin
    acc_sel = '0;
    inc_sel = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (slot_i == CW'(c)) begin
        acc_sel = acc_q[c];
        inc_sel = incr_i[c*PW +: PW];
      end
    end
  end

  assign sum = acc_sel + inc_sel;

  for (genvar c = 0; c < N_CH; c++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  acc_q[c] <= '0;
      else if (slot_i == CW'(c))    acc_q[c] <= sum;
    end

    assert_acc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_i != CW'(c) |=> $stable(acc_q[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      ch_o    <= '0;
      vld_o   <= 1'b0;
    end else begin
      phase_o <= sum;
      ch_o    <= slot_i;
      vld_o   <= 1'b1;
    end
  end

endmodule

// File: rtl/mc_dds_sine.sv
module mc_dds_sine
  import mc_dds_pkg::*;
#(
  parameter int PW     = 32,
  parameter int LUT_AW = 8,
  parameter int SW     = 16,
  parameter int CW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] phase_i,
  input  logic [CW-1:0] ch_i,
  input  logic          vld_i,
  output logic [SW-1:0] samp_o,
  output logic [CW-1:0] ch_o,
  output logic          vld_o
);

  localparam int DEPTH = 1 << LUT_AW;
  localparam int PEAK  = (1 << (SW - 1)) - 1;

  logic [SW-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam int VAL = quarter_sine(k, DEPTH, PEAK);
    assign rom[k] = SW'(VAL);
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, addr;
  logic [SW-1:0]     mag, samp_n;

  assign quad   = phase_i[PW-1 -: 2];
  assign idx    = phase_i[PW-3 -: LUT_AW];
  assign addr   = quad[0] ? ~idx : idx;   // odd quadrants run the table backward
  assign mag    = rom[addr];
  assign samp_n = quad[1] ? -mag : mag;   // lower half-period is negative

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      ch_o   <= '0;
      vld_o  <= 1'b0;
    end else begin
      samp_o <= samp_n;
      ch_o   <= ch_i;
      vld_o  <= vld_i;
    end
  end

  // Table entries are strictly positive, so the sign follows the top phase bit
  assert_sample_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o[SW-1] == $past(phase_i[PW-1]));

  assert_sample_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> samp_o != '0);

endmodule

// File: rtl/mc_dds_scale.sv
module mc_dds_scale #(
  parameter int SW = 16,
  parameter int AW = 16,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] samp_i,
  input  logic [AW-1:0] amp_i,
  input  logic [CW-1:0] ch_i,
  input  logic          vld_i,
  output logic [SW-1:0] res_o,
  output logic [CW-1:0] ch_o,
  output logic          vld_o
);

  localparam int PRW = SW + AW + 1;

  logic signed [PRW-1:0] prod, biased, shifted;
  logic        [SW-1:0]  res_n;

  assign prod    = $signed(samp_i) * $signed({1'b0, amp_i});
  // bias negatives by 2^AW-1 so the arithmetic shift truncates toward zero
  assign biased  = prod + (prod[PRW-1] ? {{(PRW-AW){1'b0}}, {AW{1'b1}}} : '0);
  assign shifted = biased >>> AW;
  assign res_n   = shifted[SW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      ch_o  <= '0;
      vld_o <= 1'b0;
    end else begin
      res_o <= res_n;
      ch_o  <= ch_i;
      vld_o <= vld_i;
    end
  end

  assert_zero_amp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_i == '0 |=> res_o == '0);

  assert_no_sign_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(samp_i[SW-1]) == 1'b0 |-> res_o[SW-1] == 1'b0);

endmodule

// File: rtl/mc_dds.sv
module mc_dds
  import mc_dds_pkg::*;
#(
  parameter int N_CH    = 5,
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 16,
  parameter int SAMP_W  = 16,
  parameter int LUT_AW  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CH*PHASE_W-1:0] incr_i,
  input  logic [N_CH*AMP_W-1:0]   amp_i,
  output logic [N_CH*SAMP_W-1:0]  wave_o,
  output logic [N_CH-1:0]         valid_o
);

  localparam int CW = idx_width(N_CH);

  logic [CW-1:0]      slot;
  logic [PHASE_W-1:0] ph_phase;
  logic [CW-1:0]      ph_ch, sn_ch, sc_ch;
  logic               ph_vld, sn_vld, sc_vld;
  logic [SAMP_W-1:0]  sn_samp, sc_res;
  logic [AMP_W-1:0]   amp_sel;
  logic [SAMP_W-1:0]  wave_q [N_CH];
  logic [N_CH-1:0]    valid_q;

  mc_dds_slot #(.N_CH(N_CH), .CW(CW)) u_slot (
    .clk_i, .rst_ni, .slot_o(slot)
  );

  mc_dds_phase #(.N_CH(N_CH), .PW(PHASE_W), .CW(CW)) u_phase (
    .clk_i, .rst_ni, .slot_i(slot), .incr_i,
    .phase_o(ph_phase), .ch_o(ph_ch), .vld_o(ph_vld)
  );

  mc_dds_sine #(.PW(PHASE_W), .LUT_AW(LUT_AW), .SW(SAMP_W), .CW(CW)) u_sine (
    .clk_i, .rst_ni, .phase_i(ph_phase), .ch_i(ph_ch), .vld_i(ph_vld),
    .samp_o(sn_samp), .ch_o(sn_ch), .vld_o(sn_vld)
  );

  always_comb begin
    amp_sel = '0;
    for (int c = 0; c < N_CH; c++)
      if (sn_ch == CW'(c)) amp_sel = amp_i[c*AMP_W +: AMP_W];
  end

  mc_dds_scale #(.SW(SAMP_W), .AW(AMP_W), .CW(CW)) u_scale (
    .clk_i, .rst_ni, .samp_i(sn_samp), .amp_i(amp_sel), .ch_i(sn_ch), .vld_i(sn_vld),
    .res_o(sc_res), .ch_o(sc_ch), .vld_o(sc_vld)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wave_q[c]  <= '0;
        valid_q[c] <= 1'b0;
      end else begin
        valid_q[c] <= sc_vld && (sc_ch == CW'(c));
        if (sc_vld && (sc_ch == CW'(c))) wave_q[c] <= sc_res;
      end
    end

    assign wave_o[c*SAMP_W +: SAMP_W] = wave_q[c];

    assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[c] |-> $stable(wave_o[c*SAMP_W +: SAMP_W]));

    if (N_CH > 1) begin : g_order
      assert_valid_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[c] |=> valid_o[(c + 1) % N_CH]);
    end
  end

  assign valid_o = valid_q;

  assert_valid_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(valid_o));

  assert_reset_clear_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (valid_o == '0 && wave_o == '0));

endmodule

// File: tb/tb_mc_dds.sv
module tb_mc_dds;

  localparam int N = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N*32-1:0] incr_v;
  logic [N*16-1:0] amp_v;
  logic [N*16-1:0] wave_o;
  logic [N-1:0]    valid_o;

  logic [31:0] incr_cur [N];
  logic [15:0] amp_cur  [N];

  always #2 clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      incr_v[c*32 +: 32] = incr_cur[c];
      amp_v[c*16 +: 16]  = amp_cur[c];
    end
  end

  mc_dds dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .incr_i(incr_v), .amp_i(amp_v),
    .wave_o(wave_o), .valid_o(valid_o)
  );

  int errors = 0;
  int checks = 0;
  int e = 0;
  string tag = "R9";

  logic [31:0] exp_acc [N];
  logic [15:0] shadow  [N];
  logic [31:0] it_ph   [4];
  int          it_ch   [4];
  logic [15:0] it_amp  [4];

  function automatic int qtab(int k);
    real x;
    x = $sin(3.141592653589793 * (real'(k) + 0.5) / 512.0) * 32767.0;
    return $rtoi(x + 0.5);
  endfunction

  function automatic int samp_of(logic [31:0] ph);
    int idx, m;
    idx = int'(ph[29:22]);
    if (ph[30]) idx = 255 - idx;
    m = qtab(idx);
    return ph[31] ? -m : m;
  endfunction

  function automatic int scale(int s, int a);
    longint p;
    p = longint'(s) * longint'(a);
    if (p < 0) p = p + 65535;
    return int'(p >>> 16);
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < N; c++) begin
      exp_acc[c] = '0;
      shadow[c]  = '0;
    end
    e = 0;
  endtask

  // One rising edge: advance the model, then compare at the falling edge
  task automatic tick();
    int ch, j;
    logic [N-1:0] ev;
    @(negedge clk_i);
    ch = e % N;
    exp_acc[ch] = exp_acc[ch] + incr_cur[ch];
    it_ph[e % 4] = exp_acc[ch];
    it_ch[e % 4] = ch;
    if (e >= 2) it_amp[(e - 2) % 4] = amp_cur[it_ch[(e - 2) % 4]];
    ev = '0;
    if (e >= 3) begin
      j = (e - 3) % 4;
      shadow[it_ch[j]] = 16'(scale(samp_of(it_ph[j]), int'(it_amp[j])));
      ev[it_ch[j]] = 1'b1;
    end
    chk(valid_o == ev, "R1 R8 valid_o", longint'(valid_o), longint'(ev));
    for (int c = 0; c < N; c++)
      chk(wave_o[c*16 +: 16] == shadow[c], {tag, " R7 wave_o"},
          longint'(wave_o[c*16 +: 16]), longint'(shadow[c]));
    e++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == '0, "R9 valid_o in reset", longint'(valid_o), 0);
    chk(wave_o == '0, "R9 wave_o in reset", longint'(wave_o[15:0]), 0);
    clear_model();
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1d5_0c3a));
    for (int c = 0; c < N; c++) begin
      incr_cur[c] = '0;
      amp_cur[c]  = '0;
    end
    clear_model();

    tag = "R9";
    do_reset();

    // R4: phase stays at 0, full amplitude shows entry 0 scaled
    tag = "R4";
    for (int c = 0; c < N; c++) amp_cur[c] = 16'hffff;
    run(12);
    chk(wave_o[15:0] == 16'(qtab(0) - 1), "R4 entry0 at full scale",
        longint'(wave_o[15:0]), longint'(qtab(0) - 1));

    // R5/R6: quadrant steps forward and backward, zero amplitude elsewhere
    tag = "R5 R6";
    incr_cur[0] = 32'h4000_0000;
    incr_cur[1] = 32'hc000_0000;
    incr_cur[2] = 32'h0123_4567;
    amp_cur[3]  = 16'h0000;
    incr_cur[3] = 32'h1111_1111;
    amp_cur[4]  = 16'h8000;
    incr_cur[4] = 32'hffff_ffff;
    run(40);
    chk(wave_o[3*16 +: 16] == 16'h0000, "R6 zero amplitude",
        longint'(wave_o[3*16 +: 16]), 0);

    // R3: only channel 2's increment changes
    tag = "R3";
    for (int i = 0; i < 30; i++) begin
      tick();
      incr_cur[2] = $urandom;
    end

    // R2/R6: random increments and amplitudes
    tag = "R2 R6";
    for (int i = 0; i < 800; i++) begin
      tick();
      if ($urandom % 6 == 0) incr_cur[$urandom % N] = $urandom;
      if ($urandom % 9 == 0) amp_cur[$urandom % N] = 16'($urandom);
    end

    // R9: reset mid-run clears accumulators
    tag = "R9";
    do_reset();
    for (int c = 0; c < N; c++) incr_cur[c] = '0;
    run(10);
    chk(wave_o[2*16 +: 16] == 16'(scale(qtab(0), int'(amp_cur[2]))),
        "R9 accumulator cleared", longint'(wave_o[2*16 +: 16]),
        longint'(16'(scale(qtab(0), int'(amp_cur[2])))));

    // R2: wraparound with large steps
    tag = "R2";
    for (int c = 0; c < N; c++) begin
      incr_cur[c] = 32'hfff0_0000 + 32'(c);
      amp_cur[c]  = 16'hffff - 16'(c * 4097);
    end
    run(60);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule